// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block drives an 8-bit processor's instruction flow one level above the bus engine. It keeps the program counter, asks the bus engine for one machine cycle at a time (opcode fetch, memory read or memory write), and takes the byte that each read returns. From the fetched opcode it works out how many further cycles the instruction needs and in what order. It updates a small register file and assembles a 16-bit direct address from two operand bytes, lower byte first.

The bus engine answers each request with one `cyc_tick` pulse per T-state, wait states included. It raises `cyc_done`, with the read data, on the last of those ticks. The sequencer adds up the ticks of every cycle of an instruction. One clock after the last cycle completes, it reports the instruction's opcode and its exact T-state count. The supported instructions are a register-to-register move, a move-immediate into a register, a direct store of the accumulator, and a halt. Execution runs from address 0 after reset and continues until a halt or an unsupported opcode.

Top module: `mcyc_sequencer`

## Requirements
- R1: While reset is held and on the first clock after it, the program counter is 0, every register is 0, `halted` and `illegal` are low, and a request is presented with `cyc_kind` 0 (opcode fetch) at address 0.
- R2: Each instruction begins with an opcode fetch, and the fetched byte is decoded as an opcode. `cyc_kind` codes are 0 for opcode fetch, 1 for memory read and 2 for memory write. The program counter rises by one after every opcode fetch and after every operand read.
- R3: Register codes are 0 for B, 1 for C, 2 for D, 3 for E, 4 for H, 5 for L and 7 for A. An opcode `01dddsss` other than 76h copies register sss into register ddd. It completes within the opcode fetch, so its count is 4 with no wait states.
- R4: An opcode `00ddd110` runs an opcode fetch followed by one memory read. The byte read is loaded into register ddd, and the count is 7 with no wait states.
- R5: Opcode 32h runs an opcode fetch, a memory read of the low address byte, a memory read of the high address byte, and a memory write of A to {high, low}. A is left unchanged, and the count is 13 with no wait states.
- R6: Opcode 76h completes after its opcode fetch with a count of 4 and sets `halted`. After that no further request is issued, and the program counter and registers hold.
- R7: Any other opcode, and any move or move-immediate that names register code 6, sets `illegal` and `halted` and changes no register. The program counter still advances past the opcode.
- R8: The reported count equals the number of `cyc_tick` pulses over all cycles of the instruction, including wait states. Clocks without a tick are not counted.
- R9: `instr_done` pulses for one clock, one clock after the `cyc_done` of the instruction's last cycle. `instr_opcode` and `instr_tstates` are valid with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | output | 1 | A machine cycle is requested |
| cyc_kind | output | 2 | Requested cycle type: 0 fetch, 1 read, 2 write |
| cyc_addr | output | 16 | Address of the requested cycle |
| cyc_wdata | output | 8 | Data for a write cycle |
| cyc_tick | input | 1 | One pulse per T-state of the running cycle |
| cyc_done | input | 1 | Last T-state of the running cycle |
| cyc_rdata | input | 8 | Byte read, valid with `cyc_done` |
| instr_done | output | 1 | Instruction finished (one-clock pulse) |
| instr_opcode | output | 8 | Opcode of the finished instruction |
| instr_tstates | output | 8 | T-state count of the finished instruction |
| pc | output | 16 | Program counter |
| reg_a | output | 8 | Accumulator |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| halted | output | 1 | Execution stopped |
| illegal | output | 1 | An unsupported opcode was fetched |

## Verification
The closing tick of an instruction's last cycle arrives in the same clock as that cycle's `cyc_done`. That single edge therefore has to both add the tick and latch the finished count. The same edge also writes a register or advances the program counter. The bus model always pairs the final tick with `done`, and runs whole programs with zero and with one wait state per cycle. Each reported count is then compared with the count the requirements give (4, 7 or 13, plus one per cycle per wait state). A dropped or doubled closing tick would shift every count by one.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2 * DATA_W;
    localparam int NUM_REGS = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);

    localparam logic [DATA_W-1:0] OP_STORE_DIRECT = 8'h32;
    localparam logic [DATA_W-1:0] OP_STOP         = 8'h76;

    localparam logic [REG_IDX_W-1:0] RCODE_B   = 3'd0;
    localparam logic [REG_IDX_W-1:0] RCODE_C   = 3'd1;
    localparam logic [REG_IDX_W-1:0] RCODE_MEM = 3'd6;
    localparam logic [REG_IDX_W-1:0] RCODE_A   = 3'd7;

    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_READ  = 2'd1,
        MC_WRITE = 2'd2
    } mcyc_e;

    typedef enum logic [2:0] {
        IK_COPY,
        IK_LOADI,
        IK_STORE,
        IK_STOP,
        IK_BAD
    } ikind_e;

    typedef enum logic [1:0] {
        SQ_FETCH,
        SQ_OPER,
        SQ_STORE,
        SQ_STOP
    } sqstate_e;

    typedef struct packed {
        ikind_e                kind;
        logic [REG_IDX_W-1:0]  dst;
        logic [REG_IDX_W-1:0]  src;
    } idec_t;

    function automatic idec_t decode_op(input logic [DATA_W-1:0] op);
        idec_t d;
        d.dst  = op[5:3];
        d.src  = op[2:0];
        d.kind = IK_BAD;
        if (op == OP_STOP) begin
            d.kind = IK_STOP;
        end else if (op[7:6] == 2'b01) begin
            d.kind = (d.dst == RCODE_MEM || d.src == RCODE_MEM) ? IK_BAD : IK_COPY;
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'b110) begin
            d.kind = (d.dst == RCODE_MEM) ? IK_BAD : IK_LOADI;
        end else if (op == OP_STORE_DIRECT) begin
            d.kind = IK_STORE;
        end
        return d;
    endfunction

endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
    import mseq_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output idec_t             dec
);

    always_comb begin
        dec = decode_op(opcode);
    end

endmodule

// File: rtl/mseq_regfile.sv
module mseq_regfile
    import mseq_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int W    = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [W-1:0]            wdata,
    input  logic [$clog2(NREG)-1:0] raddr,
    output logic [W-1:0]            rdata,
    output logic [W-1:0]            acc_q,
    output logic [W-1:0]            b_q,
    output logic [W-1:0]            c_q
);

    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && waddr == g) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[raddr];
    assign acc_q = regs[RCODE_A];
    assign b_q   = regs[RCODE_B];
    assign c_q   = regs[RCODE_C];

endmodule

// File: rtl/mseq_tcount.sv
module mseq_tcount #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          finish,
    output logic          done_q,
    output logic [CW-1:0] report_q
);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] cnt_next;

    assign cnt_next = run_cnt + (tick ? CW'(1) : CW'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            report_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                report_q <= cnt_next;
                run_cnt  <= '0;
            end else begin
                run_cnt <= cnt_next;
            end
        end
    end

    // R8: a finished instruction never reports zero T-states when the closing tick was present
    assert_closing_tick_counted_R8: assert property (@(posedge clk) disable iff (rst)
        (finish && tick) |=> (report_q != '0));

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
    import mseq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cyc_req,
    output logic [1:0]        cyc_kind,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic              cyc_tick,
    input  logic              cyc_done,
    input  logic [DATA_W-1:0] cyc_rdata,
    output logic              instr_done,
    output logic [DATA_W-1:0] instr_opcode,
    output logic [CW-1:0]     instr_tstates,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] reg_c,
    output logic              halted,
    output logic              illegal
);

    sqstate_e             state;
    logic [DATA_W-1:0]    ir;
    logic [DATA_W-1:0]    addr_lo;
    logic [DATA_W-1:0]    addr_hi;
    logic                 opnd_sel;
    logic                 illegal_q;
    logic [DATA_W-1:0]    op_q;

    logic [DATA_W-1:0]    dec_in;
    idec_t                dec;
    logic                 rf_we;
    logic [REG_IDX_W-1:0] rf_waddr;
    logic [DATA_W-1:0]    rf_wdata;
    logic [DATA_W-1:0]    rf_src;
    logic                 finish;

    assign dec_in = (state == SQ_FETCH) ? cyc_rdata : ir;

    mseq_decode u_decode (
        .opcode (dec_in),
        .dec    (dec)
    );

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = dec.dst;
        rf_wdata = rf_src;
        finish   = 1'b0;
        if (cyc_done) begin
            case (state)
                SQ_FETCH: begin
                    rf_we  = (dec.kind == IK_COPY);
                    finish = (dec.kind == IK_COPY) || (dec.kind == IK_STOP) ||
                             (dec.kind == IK_BAD);
                end
                SQ_OPER: begin
                    if (dec.kind == IK_LOADI) begin
                        rf_we    = 1'b1;
                        rf_wdata = cyc_rdata;
                        finish   = 1'b1;
                    end
                end
                SQ_STORE: finish = 1'b1;
                default:  finish = 1'b0;
            endcase
        end
    end

    mseq_regfile #(
        .NREG (NUM_REGS),
        .W    (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (dec.src),
        .rdata (rf_src),
        .acc_q (reg_a),
        .b_q   (reg_b),
        .c_q   (reg_c)
    );

    mseq_tcount #(
        .CW (CW)
    ) u_tcount (
        .clk      (clk),
        .rst      (rst),
        .tick     (cyc_tick),
        .finish   (finish),
        .done_q   (instr_done),
        .report_q (instr_tstates)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_FETCH;
            pc        <= '0;
            ir        <= '0;
            addr_lo   <= '0;
            addr_hi   <= '0;
            opnd_sel  <= 1'b0;
            illegal_q <= 1'b0;
            op_q      <= '0;
        end else begin
            if (finish) begin
                op_q <= dec_in;
            end
            if (cyc_done) begin
                case (state)
                    SQ_FETCH: begin
                        ir       <= cyc_rdata;
                        pc       <= pc + ADDR_W'(1);
                        opnd_sel <= 1'b0;
                        case (dec.kind)
                            IK_LOADI, IK_STORE: state <= SQ_OPER;
                            IK_STOP:            state <= SQ_STOP;
                            IK_BAD: begin
                                state     <= SQ_STOP;
                                illegal_q <= 1'b1;
                            end
                            default:            state <= SQ_FETCH;
                        endcase
                    end
                    SQ_OPER: begin
                        pc <= pc + ADDR_W'(1);
                        if (dec.kind == IK_LOADI) begin
                            state <= SQ_FETCH;
                        end else if (!opnd_sel) begin
                            addr_lo  <= cyc_rdata;
                            opnd_sel <= 1'b1;
                        end else begin
                            addr_hi <= cyc_rdata;
                            state   <= SQ_STORE;
                        end
                    end
                    SQ_STORE: state <= SQ_FETCH;
                    default:  state <= SQ_STOP;
                endcase
            end
        end
    end

    always_comb begin
        cyc_req   = (state != SQ_STOP);
        cyc_kind  = MC_FETCH;
        cyc_addr  = pc;
        cyc_wdata = reg_a;
        case (state)
            SQ_OPER:  cyc_kind = MC_READ;
            SQ_STORE: begin
                cyc_kind = MC_WRITE;
                cyc_addr = {addr_hi, addr_lo};
            end
            default:  cyc_kind = MC_FETCH;
        endcase
    end

    assign halted       = (state == SQ_STOP);
    assign illegal      = illegal_q;
    assign instr_opcode = op_q;

    // R2: every fetch or operand read that completes moves the program counter on by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_done && (state == SQ_FETCH || state == SQ_OPER)) |=> (pc == $past(pc) + ADDR_W'(1)));

    // R2: after a finished instruction that did not stop, the next request is an opcode fetch
    assert_fetch_first_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_done && !halted) |-> (cyc_req && cyc_kind == MC_FETCH));

    // R5: the memory write of a direct store leaves the accumulator unchanged
    assert_store_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STORE && cyc_done) |=> (reg_a == $past(reg_a)));

    // R6: once stopped, program counter and accumulator hold
    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (rst)
        halted |=> (pc == $past(pc) && reg_a == $past(reg_a) && reg_b == $past(reg_b)));

    // R7: an illegal opcode always leaves the block stopped
    assert_illegal_stops_R7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);

endmodule

// File: tb/test_mcyc_sequencer.sv
`timescale 1ns/1ps
module test_mcyc_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_req;
    logic [1:0]  cyc_kind;
    logic [15:0] cyc_addr;
    logic [7:0]  cyc_wdata;
    logic        cyc_tick = 1'b0;
    logic        cyc_done = 1'b0;
    logic [7:0]  cyc_rdata = 8'h00;
    logic        instr_done;
    logic [7:0]  instr_opcode;
    logic [7:0]  instr_tstates;
    logic [15:0] pc;
    logic [7:0]  reg_a, reg_b, reg_c;
    logic        halted, illegal;

    always #2 clk = ~clk;

    mcyc_sequencer i_mcyc_sequencer (
        .clk (clk), .rst (rst),
        .cyc_req (cyc_req), .cyc_kind (cyc_kind), .cyc_addr (cyc_addr), .cyc_wdata (cyc_wdata),
        .cyc_tick (cyc_tick), .cyc_done (cyc_done), .cyc_rdata (cyc_rdata),
        .instr_done (instr_done), .instr_opcode (instr_opcode), .instr_tstates (instr_tstates),
        .pc (pc), .reg_a (reg_a), .reg_b (reg_b), .reg_c (reg_c),
        .halted (halted), .illegal (illegal)
    );

    // program: MVI A,ABh / MVI B,45h / MVI C,3Ch / MOV B,C / STA 4050h / MOV A,B / HLT
    localparam int PLEN = 12;
    localparam logic [7:0] PROG [PLEN] = '{8'h3E, 8'hAB, 8'h06, 8'h45, 8'h0E, 8'h3C,
                                           8'h41, 8'h32, 8'h50, 8'h40, 8'h78, 8'h76};
    localparam int NI = 7;
    localparam logic [7:0] V_OP   [NI] = '{8'h3E, 8'h06, 8'h0E, 8'h41, 8'h32, 8'h78, 8'h76};
    localparam int         V_CYC  [NI] = '{2, 2, 2, 1, 4, 1, 1};
    localparam int         V_BASE [NI] = '{7, 7, 7, 4, 13, 4, 4};
    localparam logic [7:0] V_A    [NI] = '{8'hAB, 8'hAB, 8'hAB, 8'hAB, 8'hAB, 8'h3C, 8'h3C};
    localparam int NK = 13;
    localparam int EXP_KIND [NK] = '{0, 1, 0, 1, 0, 1, 0, 0, 1, 1, 2, 0, 0};

    int checks = 0;
    int failures = 0;
    logic [7:0] mem [256];
    int wait_n = 0;
    logic run_bus = 1'b0;
    int kind_log [64];
    int addr_log [64];
    int ncyc = 0;
    int op_log [32];
    int t_log [32];
    int a_log [32];
    int ndone = 0;
    int wr_cnt = 0;
    int wr_addr = 0;
    int wr_data = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus engine model: one tick per T-state, done with the last tick, idle clock after each cycle
    initial begin
        forever begin
            @(negedge clk);
            if (run_bus && cyc_req) begin
                automatic int k = int'(cyc_kind);
                automatic logic [15:0] a = cyc_addr;
                automatic int n = ((k == 0) ? 4 : 3) + wait_n;
                if (ncyc < 64) begin
                    kind_log[ncyc] = k;
                    addr_log[ncyc] = int'(a);
                end
                ncyc++;
                for (int t = 0; t < n; t++) begin
                    cyc_tick  = 1'b1;
                    cyc_done  = (t == n - 1);
                    cyc_rdata = mem[a[7:0]];
                    if (t == n - 1 && k == 2) begin
                        wr_cnt++;
                        wr_addr = int'(a);
                        wr_data = int'(cyc_wdata);
                    end
                    @(negedge clk);
                end
                cyc_tick = 1'b0;
                cyc_done = 1'b0;
            end
        end
    end

    // completion monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && instr_done && ndone < 32) begin
                op_log[ndone] = int'(instr_opcode);
                t_log[ndone]  = int'(instr_tstates);
                a_log[ndone]  = int'(reg_a);
                ndone++;
            end
        end
    end

    task automatic do_reset();
        run_bus = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        ncyc = 0; ndone = 0; wr_cnt = 0;
        rst = 1'b0;
    endtask

    task automatic run_until_stop();
        int guard = 0;
        run_bus = 1'b1;
        while (!halted && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic load_main();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < PLEN; i++) mem[i] = PROG[i];
    endtask

    task automatic run_table(input int w);
        int idx;
        load_main();
        wait_n = w;
        do_reset();
        run_until_stop();
        chk(ndone == NI, "R9 completion pulse count", ndone, NI);
        for (int i = 0; i < NI; i++) begin
            chk(op_log[i] == int'(V_OP[i]), "R9 reported opcode", op_log[i], int'(V_OP[i]));
            chk(t_log[i] == V_BASE[i] + V_CYC[i] * w, "R8 T-state count", t_log[i],
                V_BASE[i] + V_CYC[i] * w);
            chk(a_log[i] == int'(V_A[i]), "R5 accumulator after instruction", a_log[i], int'(V_A[i]));
        end
        chk(ncyc == NK, "R2 cycle count", ncyc, NK);
        for (int i = 0; i < NK; i++)
            chk(kind_log[i] == EXP_KIND[i], "R2 cycle kind order", kind_log[i], EXP_KIND[i]);
        // operand reads of the store come from consecutive addresses after its opcode
        idx = 7;
        chk(addr_log[idx] == 7 && addr_log[idx+1] == 8 && addr_log[idx+2] == 9,
            "R2 store fetch addresses", addr_log[idx+2], 9);
        chk(addr_log[idx+3] == 16'h4050, "R5 write address low byte first", addr_log[idx+3], 16'h4050);
        chk(wr_cnt == 1, "R5 single write", wr_cnt, 1);
        chk(wr_data == 8'hAB, "R5 write data is A", wr_data, 8'hAB);
        chk(reg_b == 8'h3C, "R3 B after move", int'(reg_b), 8'h3C);
        chk(reg_c == 8'h3C, "R4 C after load", int'(reg_c), 8'h3C);
        chk(reg_a == 8'h3C, "R3 A after move", int'(reg_a), 8'h3C);
        chk(halted == 1'b1 && illegal == 1'b0, "R6 halted clean", int'({halted, illegal}), 2);
        chk(pc == 16'd12, "R6 pc after halt", int'(pc), 12);
        chk(cyc_req == 1'b0, "R6 no request after halt", int'(cyc_req), 0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        load_main();
        do_reset();
        // R1: state right after reset release
        chk(pc == 16'd0, "R1 pc at reset", int'(pc), 0);
        chk(reg_a == 0 && reg_b == 0 && reg_c == 0, "R1 registers at reset",
            int'({reg_a, reg_b, reg_c}), 0);
        chk(!halted && !illegal, "R1 flags at reset", int'({halted, illegal}), 0);
        chk(cyc_req && cyc_kind == 2'd0 && cyc_addr == 16'd0, "R1 first request",
            int'({cyc_req, cyc_kind}), 4);
        chk(!instr_done, "R9 no completion at reset", int'(instr_done), 0);

        run_table(0);
        run_table(1);
        run_table(2);

        // R7: move that names code 6 after a valid load
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0] = 8'h06; mem[1] = 8'h11; mem[2] = 8'h46;
        wait_n = 0;
        do_reset();
        run_until_stop();
        chk(illegal && halted, "R7 code 6 move is illegal", int'({illegal, halted}), 3);
        chk(reg_b == 8'h11, "R7 B unchanged", int'(reg_b), 8'h11);
        chk(pc == 16'd3, "R7 pc past bad opcode", int'(pc), 3);
        chk(ndone == 2 && t_log[1] == 4, "R7 bad opcode count", t_log[1], 4);
        chk(cyc_req == 1'b0, "R7 no request after illegal", int'(cyc_req), 0);

        // R7: unknown opcode first
        mem[0] = 8'h08;
        do_reset();
        run_until_stop();
        chk(illegal && pc == 16'd1, "R7 unknown opcode", int'(pc), 1);
        chk(reg_a == 0 && reg_b == 0, "R7 registers untouched", int'({reg_a, reg_b}), 0);

        // R7: move-immediate into code 6
        mem[0] = 8'h36; mem[1] = 8'h99;
        do_reset();
        run_until_stop();
        chk(illegal && ncyc == 1 && pc == 16'd1, "R7 load to code 6", ncyc, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule